// File: doc/BRIEF.md
# Watchdog Timer with Single or Paired Restart

This block guards a small processor core against runaway code. A count advances on a tick taken from one of two sources: either the instruction rate, which is the system clock divided by four, or the rising edges of a slow free-running oscillator of about 12 kHz. The slow oscillator runs in its own clock domain and is synchronized before use. If software does not restart the count within a period of 2^n ticks, the block raises a one-cycle reset request for the chip and records a time-out flag. The exponent n lies between 8 and 11 and is set by a static configuration input.

Software restarts the count with clear strobes from instruction decode. A static option picks one of two restart modes. In the single mode, one strobe is enough. In the paired mode, two distinct strobes must both arrive before the count restarts, and they may come in either order. A halt strobe stops the count for power-down and updates the power-down and time-out flags. A wake input resumes counting from zero. A further static input can switch the watchdog off altogether.

Top module: `wdog_core`

## Requirements
- R1: After power-up reset (`rst_n` low), `rst_req`, `to_flag` and `pdf_flag` are all 0.
- R2: With the instruction source selected (`cfg_src_slow`=0), `rst_req` rises exactly 4·2^n clock cycles after the last restart, where n = 8 + `cfg_exp`. Power-up reset release, an effective clear and a wake all count as restarts.
- R3: With the slow source selected (`cfg_src_slow`=1), only rising edges of `slow_osc` advance the count. They are seen after a two-stage synchronizer. A time-out follows 2^n such edges (within one edge), and no time-out occurs while `slow_osc` is idle.
- R4: A time-out drives `rst_req` high for exactly one cycle and sets `to_flag`. The count restarts on its own, and `to_flag` stays set until a halt or power-up reset.
- R5: In single mode (`cfg_dual_clear`=0), a pulse on `clr_single` restarts the count. `clr_first` and `clr_second` have no effect.
- R6: In paired mode (`cfg_dual_clear`=1), the count restarts only once both `clr_first` and `clr_second` have been seen, in either order or in the same cycle. One of them alone does not restart the count, and `clr_single` is ignored. A time-out discards a half-seen pair.
- R7: An effective clear sets `pdf_flag` to 0.
- R8: While `cfg_enable`=0, `rst_req` never rises and clear strobes leave `pdf_flag` unchanged.
- R9: A `halt_req` pulse sets `pdf_flag`, clears `to_flag` and zeroes the count. The count then stays frozen, and clear strobes are ignored, until `wake` is pulsed. After the wake, a full period runs before the next time-out.
- R10: A restart in the same cycle as the final tick prevents the time-out. A halt in the same cycle as a clear takes priority, so `pdf_flag` ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| slow_osc | input | 1 | Slow oscillator level, asynchronous to `clk` |
| cfg_src_slow | input | 1 | Tick source: 0 = system clock / 4, 1 = slow oscillator |
| cfg_exp | input | EXP_W | Period exponent select, n = MIN_EXP + value |
| cfg_enable | input | 1 | Watchdog enable |
| cfg_dual_clear | input | 1 | 0 = single strobe restarts, 1 = pair of strobes needed |
| clr_single | input | 1 | Restart strobe used in single mode |
| clr_first | input | 1 | First strobe of the pair |
| clr_second | input | 1 | Second strobe of the pair |
| halt_req | input | 1 | Enter power-down strobe |
| wake | input | 1 | Leave power-down strobe |
| rst_req | output | 1 | One-cycle chip reset request on time-out |
| to_flag | output | 1 | Time-out status flag |
| pdf_flag | output | 1 | Power-down status flag |

## Verification
On every cycle the assertions check the following. The reset request is always a single-cycle pulse and always comes with the time-out flag set. The count never exceeds the selected period and stays frozen while halted. An effective clear always leaves the power-down flag low, and a disabled watchdog never requests a reset. Some behaviours can only be shown by the bench's directed scenarios. These are the exact period for each exponent and each tick source, the acceptance of the clear pair in either order, and the rejection of lone or wrong-mode strobes. The scenarios also cover resuming with a full period after wake and winning the race against the final tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned WD_MIN_EXP     = 8;
  localparam int unsigned WD_EXP_W       = 2;
  localparam int unsigned WD_DIV_RATIO   = 4;
  localparam int unsigned WD_SYNC_STAGES = 2;

  typedef enum logic {
    SRC_INSTR = 1'b0,
    SRC_SLOW  = 1'b1
  } wd_src_e;

  // Number of ticks in one watchdog period for a given exponent select.
  function automatic int unsigned tick_span(input int unsigned min_exp,
                                            input int unsigned sel);
    return 32'd1 << (min_exp + sel);
  endfunction

  // Width needed for the tick counter when the largest select is in use.
  function automatic int unsigned count_width(input int unsigned min_exp,
                                               input int unsigned exp_w);
    return min_exp + (32'd1 << exp_w) - 1;
  endfunction

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen
  import wdog_pkg::*;
#(
  parameter int unsigned DIV_RATIO   = WD_DIV_RATIO,
  parameter int unsigned SYNC_STAGES = WD_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_osc,
  input  logic src_slow,
  input  logic run,
  input  logic restart,
  output logic tick
);

  localparam int unsigned DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;

  // Synchronizer chain plus one history stage for the rising-edge detector.
  logic [SYNC_STAGES:0] sync_q;
  logic                 slow_edge;
  logic                 fast_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], slow_osc};
  end

  assign slow_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  generate
    if (DIV_RATIO > 1) begin : g_div
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);
      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     div_q <= '0;
        else if (restart)               div_q <= '0;
        else if (run && !src_slow) begin
          if (div_q == DIV_LAST)        div_q <= '0;
          else                          div_q <= div_q + DIV_W'(1);
        end
      end

      assign fast_tick = (div_q == DIV_LAST);
    end else begin : g_nodiv
      assign fast_tick = 1'b1;
    end
  endgenerate

  assign tick = run && (src_slow ? slow_edge : fast_tick);

endmodule

// File: rtl/wdog_period_cnt.sv
module wdog_period_cnt
  import wdog_pkg::*;
#(
  parameter int unsigned MIN_EXP = WD_MIN_EXP,
  parameter int unsigned EXP_W   = WD_EXP_W,
  localparam int unsigned CNT_W  = count_width(MIN_EXP, EXP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             expire,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] last_idx;

  assign last_idx = CNT_W'(tick_span(MIN_EXP, 32'(exp_sel)) - 1);
  assign expire   = tick && !restart && (count == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 count <= '0;
    else if (restart || expire) count <= '0;
    else if (tick)              count <= count + CNT_W'(1);
  end

endmodule

// File: rtl/wdog_clear_ctl.sv
module wdog_clear_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic dual,
  input  logic allow,
  input  logic clr_single,
  input  logic clr_first,
  input  logic clr_second,
  input  logic drop,
  output logic clr_eff
);

  logic pend_first, pend_second;
  logic seen_first, seen_second;
  logic live;

  assign live        = enable && allow;
  assign seen_first  = pend_first  || clr_first;
  assign seen_second = pend_second || clr_second;
  assign clr_eff     = live && (dual ? (seen_first && seen_second) : clr_single);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_first  <= 1'b0;
      pend_second <= 1'b0;
    end else if (clr_eff || drop) begin
      pend_first  <= 1'b0;
      pend_second <= 1'b0;
    end else if (live && dual) begin
      pend_first  <= seen_first;
      pend_second <= seen_second;
    end
  end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned MIN_EXP     = WD_MIN_EXP,
  parameter int unsigned EXP_W       = WD_EXP_W,
  parameter int unsigned DIV_RATIO   = WD_DIV_RATIO,
  parameter int unsigned SYNC_STAGES = WD_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_osc,
  input  logic             cfg_src_slow,
  input  logic [EXP_W-1:0] cfg_exp,
  input  logic             cfg_enable,
  input  logic             cfg_dual_clear,
  input  logic             clr_single,
  input  logic             clr_first,
  input  logic             clr_second,
  input  logic             halt_req,
  input  logic             wake,
  output logic             rst_req,
  output logic             to_flag,
  output logic             pdf_flag
);

  localparam int unsigned CNT_W = count_width(MIN_EXP, EXP_W);

  // Named internal events, visible to the bound checker.
  logic             halted;
  logic             halt_start;
  logic             run;
  logic             tick;
  logic             clr_eff;
  logic             restart;
  logic             expire;
  logic [CNT_W-1:0] count;

  assign halt_start = halt_req && !halted;
  assign run        = cfg_enable && !halted;
  assign restart    = clr_eff || halt_start;

  wdog_tick_gen #(
    .DIV_RATIO  (DIV_RATIO),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .slow_osc(slow_osc),
    .src_slow(cfg_src_slow == SRC_SLOW),
    .run     (run),
    .restart (restart),
    .tick    (tick)
  );

  wdog_period_cnt #(
    .MIN_EXP(MIN_EXP),
    .EXP_W  (EXP_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .restart(restart),
    .exp_sel(cfg_exp),
    .expire (expire),
    .count  (count)
  );

  wdog_clear_ctl u_clr (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cfg_enable),
    .dual      (cfg_dual_clear),
    .allow     (!halted && !halt_req),
    .clr_single(clr_single),
    .clr_first (clr_first),
    .clr_second(clr_second),
    .drop      (expire),
    .clr_eff   (clr_eff)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          halted <= 1'b0;
    else if (halt_start) halted <= 1'b1;
    else if (wake)       halted <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          to_flag <= 1'b0;
    else if (halt_start) to_flag <= 1'b0;
    else if (expire)     to_flag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pdf_flag <= 1'b0;
    else if (halt_start) pdf_flag <= 1'b1;
    else if (clr_eff)    pdf_flag <= 1'b0;
  end

endmodule

// File: rtl/wdog_core_checks.sv
module wdog_core_checks
  import wdog_pkg::*;
#(
  parameter int unsigned MIN_EXP = WD_MIN_EXP,
  parameter int unsigned EXP_W   = WD_EXP_W,
  localparam int unsigned CNT_W  = count_width(MIN_EXP, EXP_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic [EXP_W-1:0] cfg_exp,
  input logic             rst_req,
  input logic             to_flag,
  input logic             pdf_flag,
  input logic             halt_start,
  input logic             halted,
  input logic             clr_eff,
  input logic [CNT_W-1:0] count
);

  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(tick_span(MIN_EXP, 32'(cfg_exp)) - 1));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_pulse_sets_to_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> to_flag);

  assert_clear_drops_pdf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_eff |=> !pdf_flag);

  assert_silent_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && $past(!cfg_enable)) |-> !rst_req);

  assert_halt_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt_start |=> (pdf_flag && !to_flag));

  assert_frozen_in_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> $stable(count));

endmodule

bind wdog_core wdog_core_checks #(
  .MIN_EXP(MIN_EXP),
  .EXP_W  (EXP_W)
) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_enable(cfg_enable),
  .cfg_exp   (cfg_exp),
  .rst_req   (rst_req),
  .to_flag   (to_flag),
  .pdf_flag  (pdf_flag),
  .halt_start(halt_start),
  .halted    (halted),
  .clr_eff   (clr_eff),
  .count     (count)
);

// File: tb/sim_wdog_core.sv
`timescale 1ns/1ps
module sim_wdog_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_osc = 1'b0;
  logic       cfg_src_slow = 1'b0;
  logic [1:0] cfg_exp = 2'd0;
  logic       cfg_enable = 1'b1;
  logic       cfg_dual_clear = 1'b0;
  logic       clr_single = 1'b0;
  logic       clr_first = 1'b0;
  logic       clr_second = 1'b0;
  logic       halt_req = 1'b0;
  logic       wake = 1'b0;
  logic       rst_req, to_flag, pdf_flag;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit slow_en = 1'b0;
  int slow_div = 0;
  int slow_edges = 0;

  wdog_core u0 (
    .clk(clk), .rst_n(rst_n), .slow_osc(slow_osc), .cfg_src_slow(cfg_src_slow),
    .cfg_exp(cfg_exp), .cfg_enable(cfg_enable), .cfg_dual_clear(cfg_dual_clear),
    .clr_single(clr_single), .clr_first(clr_first), .clr_second(clr_second),
    .halt_req(halt_req), .wake(wake), .rst_req(rst_req), .to_flag(to_flag),
    .pdf_flag(pdf_flag)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Slow oscillator model: toggles every third falling clock edge when running.
  always @(negedge clk) begin
    if (slow_en) begin
      if (slow_div == 2) begin
        slow_div <= 0;
        if (!slow_osc) slow_edges <= slow_edges + 1;
        slow_osc <= ~slow_osc;
      end else begin
        slow_div <= slow_div + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (!done && cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int period_cycles(input int e);
    return 4 * (1 << (8 + e));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic power_up(input bit src, input int e, input bit en, input bit dual,
                          output int t0);
    @(negedge clk);
    rst_n = 1'b0;
    clr_single = 0; clr_first = 0; clr_second = 0; halt_req = 0; wake = 0;
    cfg_src_slow = src; cfg_exp = 2'(e); cfg_enable = en; cfg_dual_clear = dual;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t0 = cyc;
  endtask

  // which: 0 single, 1 first, 2 second, 3 both of pair, 4 halt, 5 wake, 6 halt+single
  task automatic strobe(input int which, output int t);
    @(negedge clk);
    clr_single = (which == 0) || (which == 6);
    clr_first  = (which == 1) || (which == 3);
    clr_second = (which == 2) || (which == 3);
    halt_req   = (which == 4) || (which == 6);
    wake       = (which == 5);
    @(posedge clk);
    #1 t = cyc;
    @(negedge clk);
    clr_single = 0; clr_first = 0; clr_second = 0; halt_req = 0; wake = 0;
  endtask

  task automatic wait_rst(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (rst_req) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic test_reset_state();
    int t0;
    power_up(0, 0, 1, 0, t0);
    chk(!rst_req, "R1 rst_req", rst_req, 0);
    chk(!to_flag, "R1 to_flag", to_flag, 0);
    chk(!pdf_flag, "R1 pdf_flag", pdf_flag, 0);
  endtask

  task automatic test_fast_periods();
    int t0, at, at2;
    for (int e = 0; e < 4; e++) begin
      power_up(0, e, 1, 0, t0);
      wait_rst(9000, at);
      chk(at - t0 == period_cycles(e), "R2 fast period", at - t0, period_cycles(e));
      chk(to_flag, "R4 to_flag set", to_flag, 1);
      @(negedge clk);
      chk(!rst_req, "R4 one-cycle pulse", rst_req, 0);
      if (e < 2) begin
        wait_rst(9000, at2);
        chk(at2 - at == period_cycles(e), "R4 auto restart", at2 - at, period_cycles(e));
        chk(to_flag, "R4 to_flag held", to_flag, 1);
      end
    end
  endtask

  task automatic test_single_mode();
    int t0, t, t1, at;
    power_up(0, 0, 1, 0, t0);
    repeat (300) @(negedge clk);
    strobe(1, t);
    strobe(2, t);
    wait_rst(3000, at);
    chk(at - t0 == 1024, "R5 pair strobes ignored", at - t0, 1024);
    repeat (200) @(negedge clk);
    strobe(0, t1);
    wait_rst(3000, at);
    chk(at - t1 == 1024, "R5 single restart", at - t1, 1024);
  endtask

  task automatic test_dual_mode();
    int t0, t, t1, at, prev;
    power_up(0, 0, 1, 1, t0);
    repeat (100) @(negedge clk);
    strobe(0, t);
    wait_rst(3000, at);
    chk(at - t0 == 1024, "R6 single ignored", at - t0, 1024);
    strobe(2, t);
    repeat (50) @(negedge clk);
    strobe(1, t1);
    wait_rst(3000, at);
    chk(at - t1 == 1024, "R6 reverse order", at - t1, 1024);
    strobe(3, t1);
    wait_rst(3000, at);
    chk(at - t1 == 1024, "R6 same cycle pair", at - t1, 1024);
    prev = at;
    strobe(1, t);
    wait_rst(3000, at);
    chk(at - prev == 1024, "R6 lone first", at - prev, 1024);
    prev = at;
    strobe(2, t);
    wait_rst(3000, at);
    chk(at - prev == 1024, "R6 pending dropped by timeout", at - prev, 1024);
  endtask

  task automatic test_disabled();
    int t0, t, at;
    power_up(0, 0, 0, 0, t0);
    strobe(4, t);
    strobe(5, t);
    chk(pdf_flag, "R9 halt sets pdf while off", pdf_flag, 1);
    strobe(0, t);
    chk(pdf_flag, "R8 clear ignored while off", pdf_flag, 1);
    wait_rst(3000, at);
    chk(at == -1, "R8 no reset while off", at, -1);
  endtask

  task automatic test_halt();
    int t0, t, tw, at;
    power_up(0, 0, 1, 0, t0);
    wait_rst(3000, at);
    chk(to_flag, "R4 to before halt", to_flag, 1);
    repeat (100) @(negedge clk);
    strobe(4, t);
    chk(pdf_flag, "R9 pdf on halt", pdf_flag, 1);
    chk(!to_flag, "R9 to cleared on halt", to_flag, 0);
    strobe(0, t);
    chk(pdf_flag, "R9 clear ignored in halt", pdf_flag, 1);
    wait_rst(3000, at);
    chk(at == -1, "R9 frozen in halt", at, -1);
    strobe(5, tw);
    wait_rst(3000, at);
    chk(at - tw == 1024, "R9 full period after wake", at - tw, 1024);
    strobe(0, t);
    chk(!pdf_flag, "R7 clear drops pdf", pdf_flag, 0);
  endtask

  task automatic test_priority();
    int t0, t1, t, at;
    power_up(0, 0, 1, 0, t0);
    while (cyc < t0 + 1023) @(negedge clk);
    clr_single = 1'b1;
    @(posedge clk);
    #1 t1 = cyc;
    @(negedge clk);
    clr_single = 1'b0;
    chk(!rst_req, "R10 clear beats final tick", rst_req, 0);
    chk(t1 == t0 + 1024, "R10 clear on final tick edge", t1, t0 + 1024);
    wait_rst(3000, at);
    chk(at - t1 == 1024, "R10 period after late clear", at - t1, 1024);
    strobe(6, t);
    chk(pdf_flag, "R10 halt over clear", pdf_flag, 1);
  endtask

  task automatic test_slow_source();
    int t0, t, at, base;
    slow_en = 1'b0;
    slow_osc = 1'b0;
    power_up(1, 0, 1, 0, t0);
    wait_rst(3000, at);
    chk(at == -1, "R3 idle slow source", at, -1);
    strobe(0, t);
    base = slow_edges;
    slow_en = 1'b1;
    wait_rst(4000, at);
    chk(at != -1, "R3 slow timeout seen", at, 1);
    chk((slow_edges - base >= 255) && (slow_edges - base <= 257),
        "R3 slow edge count", slow_edges - base, 256);
    slow_en = 1'b0;
  endtask

  initial begin
    test_reset_state();
    test_fast_periods();
    test_single_mode();
    test_dual_mode();
    test_disabled();
    test_halt();
    test_priority();
    test_slow_source();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule